// File: doc/BRIEF.md
# Row/Column Configuration Store Port

This block loads and reads back the configuration storage of a small programmable logic core. A host on the other side of an asynchronous, strobe-driven parallel bus supplies a row address, a column address and one data byte. It then raises a write strobe or a read strobe. The two strobes cross into the local clock domain through two-flop synchronisers. The controller starts an access on the synchronised rising edge of a strobe.

A row decoder and a column decoder together pick one byte of a 64 x 32 byte array. A write stores the byte. A read returns it on an 8-bit output, so that the host can compare it with what it wrote and find storage cells that do not hold their value. An acknowledge output completes a four-phase handshake with the host. A separate fabric-side port gives the logic core a combinational view of any byte in the array.

The address and data inputs must be stable from before the strobe rises until after it falls. The controller captures them one cycle after it sees the synchronised edge.

Top module: `cfg_store_port`

## Requirements
- R1: While and after reset, `ack` is 0, `rdData` is 0x00, and every byte of the array reads 0x00.
- R2: On a rising edge of `wrStb`, the byte `wrData` is stored at (`rowAddr`, `colAddr`) when the address is in range. `ack` rises between 3 and 6 clock cycles after the strobe rises. The write is visible once `ack` is high.
- R3: On a rising edge of `rdStb`, the byte at (`rowAddr`, `colAddr`) appears on `rdData` no later than the clock cycle in which `ack` rises.
- R4: `ack` stays high as long as either strobe is held high. It falls within 5 cycles after both strobes are low. Each access gives exactly one `ack` pulse.
- R5: A write with `rowAddr` >= 64 or `colAddr` >= 32 changes no byte of the array. In particular, row 64 and column 32 do not alias onto row 0 or column 0.
- R6: A read with `rowAddr` >= 64 or `colAddr` >= 32 returns 0x00 on `rdData`.
- R7: When the write and read strobes rise in the same synchronised cycle, the write is performed and the read is dropped, so `rdData` keeps its previous value.
- R8: `fabData` combinationally shows the array byte at (`fabRow`, `fabCol`), and it shows any committed write.
- R9: `rdData` changes only in the cycle in which `ack` rises for a read. It holds its value across writes and idle time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrStb | input | 1 | Host write strobe, asynchronous |
| rdStb | input | 1 | Host read strobe, asynchronous |
| rowAddr | input | 7 | Host row address; values 0 to 63 are implemented |
| colAddr | input | 6 | Host column address; values 0 to 31 are implemented |
| wrData | input | 8 | Host write byte |
| rdData | output | 8 | Readback byte, held until the next read |
| ack | output | 1 | Four-phase handshake acknowledge |
| fabRow | input | 6 | Fabric-side row index |
| fabCol | input | 5 | Fabric-side column index |
| fabData | output | 8 | Fabric-side view of the selected byte |

## Verification
A write and a read can start in the same synchronised cycle when the host raises both strobes on the same clock. The bench provokes this by driving both strobes together. Only one acknowledge is expected, and `rdData` must still hold the value of the previous read. A later read of the target byte must return the newly written value. The bench also releases the strobes one at a time and checks that the acknowledge stays high until the second strobe falls.

// File: rtl/cfg_store_pkg.sv
package cfg_store_pkg;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic capture;      // latch address and data from the host pins
    logic commitWrite;  // write the captured byte into the array
    logic loadRead;     // load the readback register
  } dpCmd_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WCAP,
    ST_WCOMMIT,
    ST_RCAP,
    ST_RLOAD,
    ST_HOLD
  } ctrlState_t;

endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] stage [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : gStage
    if (s == 0) begin : gFirst
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stage[s] <= '0;
        else       stage[s] <= asyncIn;
      end
    end else begin : gNext
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stage[s] <= '0;
        else       stage[s] <= stage[s-1];
      end
    end
  end

  assign syncOut = stage[STAGES-1];

endmodule

// File: rtl/cfg_decoder.sv
module cfg_decoder #(
  parameter int N  = 64,
  parameter int AW = 7
) (
  input  logic [AW-1:0] addr,
  output logic [N-1:0]  sel,
  output logic          hit
);

  always_comb begin
    sel = '0;
    for (int i = 0; i < N; i++) begin
      if (addr == AW'(i)) sel[i] = 1'b1;
    end
  end

  assign hit = |sel;

endmodule

// File: rtl/cfg_store_ctrl.sv
module cfg_store_ctrl
  import cfg_store_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   wrSync,
  input  logic   rdSync,
  output dpCmd_t cmd,
  output logic   ack
);

  ctrlState_t state, nextState;
  logic wrPrev, rdPrev;
  logic wrRise, rdRise;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPrev <= 1'b0;
      rdPrev <= 1'b0;
      state  <= ST_IDLE;
    end else begin
      wrPrev <= wrSync;
      rdPrev <= rdSync;
      state  <= nextState;
    end
  end

  assign wrRise = wrSync & ~wrPrev;
  assign rdRise = rdSync & ~rdPrev;

  always_comb begin
    nextState = state;
    cmd       = '0;
    unique case (state)
      ST_IDLE: begin
        // the write wins when both edges land together
        if (wrRise)      nextState = ST_WCAP;
        else if (rdRise) nextState = ST_RCAP;
      end
      ST_WCAP: begin
        cmd.capture = 1'b1;
        nextState   = ST_WCOMMIT;
      end
      ST_WCOMMIT: begin
        cmd.commitWrite = 1'b1;
        nextState       = ST_HOLD;
      end
      ST_RCAP: begin
        cmd.capture = 1'b1;
        nextState   = ST_RLOAD;
      end
      ST_RLOAD: begin
        cmd.loadRead = 1'b1;
        nextState    = ST_HOLD;
      end
      ST_HOLD: begin
        if (!wrSync && !rdSync) nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  assign ack = (state == ST_HOLD);

endmodule

// File: rtl/cfg_store_dp.sv
module cfg_store_dp
  import cfg_store_pkg::*;
#(
  parameter int ROWS = 64,
  parameter int COLS = 32,
  parameter int DW   = 8,
  parameter int RAW  = 7,
  parameter int CAW  = 6,
  localparam int RIW = $clog2(ROWS),
  localparam int CIW = $clog2(COLS)
) (
  input  logic           clk,
  input  logic           rstN,
  input  dpCmd_t         cmd,
  input  logic [RAW-1:0] rowAddr,
  input  logic [CAW-1:0] colAddr,
  input  logic [DW-1:0]  wrData,
  output logic [DW-1:0]  rdData,
  input  logic [RIW-1:0] fabRow,
  input  logic [CIW-1:0] fabCol,
  output logic [DW-1:0]  fabData
);

  logic [RAW-1:0] capRow;
  logic [CAW-1:0] capCol;
  logic [DW-1:0]  capData;
  logic [ROWS-1:0] rowSel;
  logic [COLS-1:0] colSel;
  logic rowHit, colHit;
  logic [DW-1:0] mem [ROWS][COLS];
  logic [DW-1:0] arrayByte;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capRow  <= '0;
      capCol  <= '0;
      capData <= '0;
    end else if (cmd.capture) begin
      capRow  <= rowAddr;
      capCol  <= colAddr;
      capData <= wrData;
    end
  end

  cfg_decoder #(.N(ROWS), .AW(RAW)) uRowDec (
    .addr(capRow), .sel(rowSel), .hit(rowHit)
  );

  cfg_decoder #(.N(COLS), .AW(CAW)) uColDec (
    .addr(capCol), .sel(colSel), .hit(colHit)
  );

  for (genvar r = 0; r < ROWS; r++) begin : gRow
    for (genvar c = 0; c < COLS; c++) begin : gCol
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)
          mem[r][c] <= '0;
        else if (cmd.commitWrite && rowSel[r] && colSel[c])
          mem[r][c] <= capData;
      end
    end
  end

  assign arrayByte = mem[capRow[RIW-1:0]][capCol[CIW-1:0]];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      rdData <= '0;
    else if (cmd.loadRead)
      rdData <= (rowHit && colHit) ? arrayByte : '0;
  end

  assign fabData = mem[fabRow][fabCol];

endmodule

// File: rtl/cfg_store_port.sv
module cfg_store_port
  import cfg_store_pkg::*;
#(
  parameter int ROWS = 64,
  parameter int COLS = 32,
  parameter int DW   = 8,
  parameter int RAW  = 7,
  parameter int CAW  = 6,
  localparam int RIW = $clog2(ROWS),
  localparam int CIW = $clog2(COLS)
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           wrStb,
  input  logic           rdStb,
  input  logic [RAW-1:0] rowAddr,
  input  logic [CAW-1:0] colAddr,
  input  logic [DW-1:0]  wrData,
  output logic [DW-1:0]  rdData,
  output logic           ack,
  input  logic [RIW-1:0] fabRow,
  input  logic [CIW-1:0] fabCol,
  output logic [DW-1:0]  fabData
);

  logic [1:0] strobeSync;
  logic wrSync, rdSync;
  dpCmd_t cmd;

  cfg_sync #(.WIDTH(2), .STAGES(2)) uSync (
    .clk(clk), .rstN(rstN),
    .asyncIn({rdStb, wrStb}),
    .syncOut(strobeSync)
  );

  assign wrSync = strobeSync[0];
  assign rdSync = strobeSync[1];

  cfg_store_ctrl uCtrl (
    .clk(clk), .rstN(rstN),
    .wrSync(wrSync), .rdSync(rdSync),
    .cmd(cmd), .ack(ack)
  );

  cfg_store_dp #(
    .ROWS(ROWS), .COLS(COLS), .DW(DW), .RAW(RAW), .CAW(CAW)
  ) uDp (
    .clk(clk), .rstN(rstN), .cmd(cmd),
    .rowAddr(rowAddr), .colAddr(colAddr), .wrData(wrData),
    .rdData(rdData),
    .fabRow(fabRow), .fabCol(fabCol), .fabData(fabData)
  );

endmodule

// File: rtl/cfg_store_port_chk.sv
module cfg_store_port_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rstN,
  input logic          ack,
  input logic [DW-1:0] rdData,
  input logic          wrSync,
  input logic          rdSync,
  input logic          capture,
  input logic          commitWrite,
  input logic          loadRead
);

  assert_cmd_onehot_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({capture, commitWrite, loadRead}));

  assert_capture_before_commit_R2: assert property (@(posedge clk) disable iff (!rstN)
    commitWrite |-> $past(capture));

  assert_capture_before_load_R3: assert property (@(posedge clk) disable iff (!rstN)
    loadRead |-> $past(capture));

  assert_ack_after_access_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ack) |-> $past(commitWrite || loadRead));

  assert_ack_release_R4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ack) |-> (!$past(wrSync) && !$past(rdSync)));

  assert_rddata_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(rdData) |-> $rose(ack));

endmodule

bind cfg_store_port cfg_store_port_chk #(.DW(DW)) uChk (
  .clk(clk), .rstN(rstN), .ack(ack), .rdData(rdData),
  .wrSync(wrSync), .rdSync(rdSync),
  .capture(cmd.capture), .commitWrite(cmd.commitWrite),
  .loadRead(cmd.loadRead)
);

// File: tb/cfg_store_port_test.sv
`timescale 1ns/1ps
module cfg_store_port_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrStb = 1'b0, rdStb = 1'b0;
  logic [6:0] rowAddr = '0;
  logic [5:0] colAddr = '0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic       ack;
  logic [5:0] fabRow = '0;
  logic [4:0] fabCol = '0;
  logic [7:0] fabData;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [7:0] model [64][32];
  logic [7:0] lastRead = 8'h00;
  logic [7:0] expQ [$];
  string      tagQ [$];
  bit         readPending = 0;

  always #2 clk = ~clk;

  cfg_store_port uut (
    .clk(clk), .rstN(rstN), .wrStb(wrStb), .rdStb(rdStb),
    .rowAddr(rowAddr), .colAddr(colAddr), .wrData(wrData),
    .rdData(rdData), .ack(ack),
    .fabRow(fabRow), .fabCol(fabCol), .fabData(fabData)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: on each acknowledge of a read, compare against the scoreboard
  initial begin
    bit ackPrev = 0;
    forever begin
      @(negedge clk);
      if (ack && !ackPrev && readPending) begin
        logic [7:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(rdData == e, t, rdData, e);
        lastRead = rdData;
        readPending = 0;
      end
      ackPrev = ack;
    end
  end

  task automatic waitAck(input string req);
    int n = 0;
    while (!ack && n < 20) begin
      @(negedge clk);
      n++;
    end
    check(ack && n >= 3 && n <= 6, req, n, 5);
  endtask

  task automatic waitRelease();
    int n = 0;
    while (ack && n < 20) begin
      @(negedge clk);
      n++;
    end
    check(!ack && n <= 5, "R4 ack release", n, 3);
  endtask

  task automatic hostWrite(input int r, input int c, input logic [7:0] d);
    @(negedge clk);
    rowAddr = 7'(r);
    colAddr = 6'(c);
    wrData = d;
    @(negedge clk);
    wrStb = 1'b1;
    waitAck("R2 write ack latency");
    if (r < 64 && c < 32) model[r][c] = d;
    repeat (2) @(negedge clk);
    wrStb = 1'b0;
    waitRelease();
  endtask

  task automatic hostRead(input int r, input int c, input string tag);
    logic [7:0] e;
    e = (r < 64 && c < 32) ? model[r][c] : 8'h00;
    expQ.push_back(e);
    tagQ.push_back(tag);
    @(negedge clk);
    rowAddr = 7'(r);
    colAddr = 6'(c);
    readPending = 1;
    @(negedge clk);
    rdStb = 1'b1;
    waitAck("R3 read ack latency");
    repeat (2) @(negedge clk);
    rdStb = 1'b0;
    waitRelease();
  endtask

  task automatic fabCheck(input int r, input int c, input string tag);
    @(negedge clk);
    fabRow = 6'(r);
    fabCol = 5'(c);
    #1;
    check(fabData == model[r][c], tag, fabData, model[r][c]);
  endtask

  initial begin
    for (int r = 0; r < 64; r++)
      for (int c = 0; c < 32; c++) model[r][c] = 8'h00;

    repeat (3) @(negedge clk);
    check(ack == 1'b0, "R1 reset ack", ack, 0);
    check(rdData == 8'h00, "R1 reset rdData", rdData, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R1: whole array clear, seen through the fabric port
    begin
      int bad = 0;
      for (int r = 0; r < 64; r++)
        for (int c = 0; c < 32; c++) begin
          fabRow = 6'(r);
          fabCol = 5'(c);
          #0.1;
          if (fabData != 8'h00) bad++;
        end
      check(bad == 0, "R1 array clear", bad, 0);
    end
    hostRead(5, 7, "R1 readback of untouched byte");

    // R2/R3: write and read back several patterns and corners
    hostWrite(0, 0, 8'hA5);
    hostWrite(63, 31, 8'h3C);
    hostWrite(17, 9, 8'hFF);
    hostWrite(40, 20, 8'h01);
    hostRead(0, 0, "R3 readback 0,0");
    hostRead(63, 31, "R3 readback 63,31");
    hostRead(17, 9, "R3 readback 17,9");
    hostRead(40, 20, "R3 readback 40,20");
    hostWrite(17, 9, 8'h5A);
    hostRead(17, 9, "R2 overwrite 17,9");

    // R8: fabric view tracks committed writes
    fabCheck(63, 31, "R8 fabric 63,31");
    fabCheck(17, 9, "R8 fabric 17,9");

    // R9: a write does not disturb rdData
    hostWrite(2, 2, 8'h77);
    check(rdData == lastRead, "R9 rdData held over write", rdData, lastRead);

    // R5: out-of-range writes touch nothing (no aliasing on row 0 / column 0)
    hostWrite(64, 0, 8'hEE);
    hostWrite(0, 32, 8'hDD);
    hostWrite(127, 63, 8'hCC);
    hostRead(0, 0, "R5 row 0 col 0 unchanged");
    fabCheck(0, 0, "R5 fabric 0,0 unchanged");

    // R6: out-of-range reads give zero
    hostRead(64, 0, "R6 row out of range");
    hostRead(3, 32, "R6 column out of range");

    // R4: ack held while the strobe is held
    @(negedge clk);
    rowAddr = 7'd9; colAddr = 6'd4; wrData = 8'h42;
    @(negedge clk);
    wrStb = 1'b1;
    waitAck("R2 write ack latency");
    model[9][4] = 8'h42;
    repeat (10) @(negedge clk);
    check(ack == 1'b1, "R4 ack held with strobe", ack, 1);
    wrStb = 1'b0;
    waitRelease();

    // R7: both strobes rise together; write wins, read dropped
    hostRead(63, 31, "R7 setup read");
    @(negedge clk);
    rowAddr = 7'd1; colAddr = 6'd1; wrData = 8'h5C;
    @(negedge clk);
    wrStb = 1'b1;
    rdStb = 1'b1;
    waitAck("R7 combined ack latency");
    model[1][1] = 8'h5C;
    check(rdData == lastRead, "R7 read dropped", rdData, lastRead);
    wrStb = 1'b0;
    repeat (6) @(negedge clk);
    check(ack == 1'b1, "R4 ack held by remaining strobe", ack, 1);
    rdStb = 1'b0;
    waitRelease();
    fabCheck(1, 1, "R7 write performed");
    hostRead(1, 1, "R7 readback of combined write");

    repeat (5) @(negedge clk);
    check(expQ.size() == 0, "R4 one ack per read", expQ.size(), 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule